// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous RAM

This block is a single-port synchronous RAM for a datapath that needs to update parts of a word. Every input (address, write data, the three chip selects and the write controls) is sampled on the rising clock edge into an input stage. A registered write commits to the storage array on the following edge. A registered read fetches the word on the following edge into an output register. Read data therefore appears on the output one clock after its address was captured.

Writes are controlled at two levels. A global write strobe stores every byte lane. Without it, a byte-write strobe lets four per-lane enables pick any subset of the lanes. Lanes that are not picked keep their contents. Each lane is eight data bits, plus an optional ninth bit that is stored alongside them and is normally used for parity. An enable-delay register follows the selected read into the output stage, and a combinational output-enable then decides whether the registered word is driven.

Top module: `bwsram_top`

## Requirements
- R1: A selected read captured at rising edge N presents the stored word on `dout_o`, with `dout_drive_o` high, after edge N+1 while `oe_n_i` is low. A read that immediately follows a write to the same address returns the newly written data.
- R2: When selected with `gw_n_i` low, all four lanes are written, whatever `bwe_n_i` and `lane_n_i` are.
- R3: When selected with `gw_n_i` high and `bwe_n_i` low, each lane k whose `lane_n_i[k]` is low is written. Lane k occupies bits `[k*LANE_W +: LANE_W]`, so lane 0 is the lowest byte. Any combination of lanes, including none, can be written in one cycle.
- R4: Lanes that a write does not enable keep their previous contents.
- R5: When `gw_n_i` and `bwe_n_i` are both high, the cycle is a read and the array is not changed, even if lane enables are low.
- R6: The block is selected only when `cs_n_i` is low, `cs_hi_i` is high and `cs2_n_i` is low. An unselected cycle neither writes nor produces a driven read one clock later.
- R7: `dout_drive_o` is high only when the enable-delay register holds a read and `oe_n_i` is low. `oe_n_i` acts without a clock. While `dout_drive_o` is low, `dout_o` is all zeros.
- R8: With `PARITY`=1, each lane is 9 bits wide (36 in total) and bit 8 of each lane is stored and returned like the data bits. With `PARITY`=0, the word is 32 bits.
- R9: During and right after reset, `dout_drive_o` is low and `dout_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data, four lanes of LANE_W bits |
| cs_n_i | input | 1 | Chip select, active low |
| cs_hi_i | input | 1 | Chip select, active high |
| cs2_n_i | input | 1 | Second active-low chip select |
| gw_n_i | input | 1 | Global write, active low, writes all lanes |
| bwe_n_i | input | 1 | Byte-write strobe, active low, qualifies lane enables |
| lane_n_i | input | 4 | Per-lane write enables, active low |
| oe_n_i | input | 1 | Output enable, active low, combinational |
| dout_o | output | DATA_W | Registered read data, zero when not driven |
| dout_drive_o | output | 1 | High when the read data is driven |

## Verification
A corrupted lane mask in the input stage shows up at the next read of the affected address as a single wrong lane, and it can appear many cycles later. For this reason the bench keeps a byte-merged copy of the array and reads every written word back. A wrong enable-delay bit shows at once, two clocks after the offending cycle, as `dout_drive_o` asserted after a write or a deselected cycle, or missing after a read. A bad output register shows in that same cycle as a wrong word.

// File: rtl/bwsram_pkg.sv
package bwsram_pkg;
  localparam int LANES = 4;

  // Three-way select: two active-low enables and one active-high enable.
  function automatic logic chip_selected(input logic cs_n, input logic cs_hi, input logic cs2_n);
    return !cs_n && cs_hi && !cs2_n;
  endfunction

  // Lane write mask: global write dominates, else byte strobe qualifies lane enables.
  function automatic logic [LANES-1:0] lane_mask(input logic gw_n, input logic bwe_n,
                                                 input logic [LANES-1:0] lane_n);
    if (!gw_n)       return {LANES{1'b1}};
    else if (!bwe_n) return ~lane_n;
    else             return '0;
  endfunction

  // A cycle is a read when neither write strobe is active.
  function automatic logic is_read(input logic gw_n, input logic bwe_n);
    return gw_n && bwe_n;
  endfunction
endpackage

// File: rtl/bwsram_inreg.sv
module bwsram_inreg #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cs_n_i,
  input  logic              cs_hi_i,
  input  logic              cs2_n_i,
  input  logic              gw_n_i,
  input  logic              bwe_n_i,
  input  logic [3:0]        lane_n_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [3:0]        wr_lanes_q,
  output logic              rd_q
);
  logic sel;
  assign sel = bwsram_pkg::chip_selected(cs_n_i, cs_hi_i, cs2_n_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      wdata_q    <= '0;
      wr_lanes_q <= '0;
      rd_q       <= 1'b0;
    end else begin
      addr_q     <= addr_i;
      wdata_q    <= wdata_i;
      wr_lanes_q <= sel ? bwsram_pkg::lane_mask(gw_n_i, bwe_n_i, lane_n_i) : 4'h0;
      rd_q       <= sel && bwsram_pkg::is_read(gw_n_i, bwe_n_i);
    end
  end
endmodule

// File: rtl/bwsram_array.sv
module bwsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic                clk,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [4*LANE_W-1:0] wdata,
  input  logic [3:0]          we_lanes,
  output logic [4*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (we_lanes[g]) store[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = store[addr];
  end
endmodule

// File: rtl/bwsram_outstage.sv
module bwsram_outstage #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_q,
  input  logic [DATA_W-1:0] rdata,
  input  logic              oe_n_i,
  output logic              out_en_q,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_drive_o
);
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      out_en_q <= 1'b0;
    end else begin
      out_en_q <= rd_q;
      if (rd_q) data_q <= rdata;
    end
  end

  assign dout_drive_o = out_en_q && !oe_n_i;
  assign dout_o       = dout_drive_o ? data_q : '0;
endmodule

// File: rtl/bwsram_top.sv
module bwsram_top #(
  parameter int ADDR_W = 6,
  parameter int PARITY = 1,
  localparam int LANE_W = 8 + PARITY,
  localparam int DATA_W = 4 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cs_n_i,
  input  logic              cs_hi_i,
  input  logic              cs2_n_i,
  input  logic              gw_n_i,
  input  logic              bwe_n_i,
  input  logic [3:0]        lane_n_i,
  input  logic              oe_n_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_drive_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata;
  logic [3:0]        wr_lanes;
  logic              rd_pend;
  logic              out_en;

  bwsram_inreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_inreg (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
    .cs_n_i(cs_n_i), .cs_hi_i(cs_hi_i), .cs2_n_i(cs2_n_i),
    .gw_n_i(gw_n_i), .bwe_n_i(bwe_n_i), .lane_n_i(lane_n_i),
    .addr_q(addr_q), .wdata_q(wdata_q), .wr_lanes_q(wr_lanes), .rd_q(rd_pend)
  );

  bwsram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_array (
    .clk(clk), .addr(addr_q), .wdata(wdata_q), .we_lanes(wr_lanes), .rdata(rdata)
  );

  bwsram_outstage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .rd_q(rd_pend), .rdata(rdata), .oe_n_i(oe_n_i),
    .out_en_q(out_en), .dout_o(dout_o), .dout_drive_o(dout_drive_o)
  );
endmodule

// File: rtl/bwsram_chk.sv
module bwsram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n_i,
  input logic              cs_hi_i,
  input logic              cs2_n_i,
  input logic              gw_n_i,
  input logic              bwe_n_i,
  input logic [3:0]        lane_n_i,
  input logic              oe_n_i,
  input logic [3:0]        wr_lanes,
  input logic              rd_pend,
  input logic              out_en,
  input logic [DATA_W-1:0] dout_o,
  input logic              dout_drive_o
);
  logic sel;
  assign sel = !cs_n_i && cs_hi_i && !cs2_n_i;

  assert_global_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !gw_n_i) |=> (wr_lanes == 4'hF));

  assert_byte_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && gw_n_i && !bwe_n_i) |=> (wr_lanes == ~$past(lane_n_i)));

  assert_read_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_n_i && bwe_n_i) |=> (wr_lanes == 4'h0));

  assert_deselect_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (wr_lanes == 4'h0 && !rd_pend));

  assert_read_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |=> out_en);

  assert_no_spurious_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_pend |=> !out_en);

  assert_drive_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dout_drive_o |-> (!oe_n_i && out_en));

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_drive_o |-> (dout_o == '0));
endmodule

bind bwsram_top bwsram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .cs_hi_i(cs_hi_i), .cs2_n_i(cs2_n_i),
  .gw_n_i(gw_n_i), .bwe_n_i(bwe_n_i), .lane_n_i(lane_n_i), .oe_n_i(oe_n_i),
  .wr_lanes(wr_lanes), .rd_pend(rd_pend), .out_en(out_en),
  .dout_o(dout_o), .dout_drive_o(dout_drive_o)
);

// File: tb/tb_bwsram_top.sv
module tb_bwsram_top;
  localparam int PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int LANE_W = 9;
  localparam int DATA_W = 36;
  localparam int DEPTH  = 64;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic cs_n = 1'b1, cs_hi = 1'b0, cs2_n = 1'b1;
  logic gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
  logic [3:0] lane_n = 4'hF;
  logic [DATA_W-1:0] dout;
  logic drive;

  bwsram_top #(.ADDR_W(ADDR_W), .PARITY(1)) dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
    .cs_n_i(cs_n), .cs_hi_i(cs_hi), .cs2_n_i(cs2_n), .gw_n_i(gw_n),
    .bwe_n_i(bwe_n), .lane_n_i(lane_n), .oe_n_i(oe_n),
    .dout_o(dout), .dout_drive_o(drive)
  );

  typedef struct {
    int          cyc;
    logic        rd;
    logic [35:0] data;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [35:0] ref_mem [DEPTH];
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw, input logic [3:0] m);
    logic [35:0] r = old;
    for (int k = 0; k < 4; k++)
      if (m[k]) r[k*LANE_W +: LANE_W] = nw[k*LANE_W +: LANE_W];
    return r;
  endfunction

  function automatic logic [35:0] pattern(input int a, input int salt);
    logic [35:0] r;
    for (int k = 0; k < 4; k++)
      r[k*LANE_W +: LANE_W] = {1'((a + k + salt) & 1), 8'((a * 13 + k * 41 + salt * 7) & 255)};
    return r;
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected output two clocks later.
  task automatic op(input int a, input logic [35:0] d, input logic csn, input logic cshi,
                    input logic cs2n, input logic gwn, input logic bwen, input logic [3:0] ln,
                    input logic oen, input string tag);
    logic [3:0] m;
    logic sel, rd;
    exp_t e;
    @(posedge clk); #1;
    addr = ADDR_W'(a); wdata = d; cs_n = csn; cs_hi = cshi; cs2_n = cs2n;
    gw_n = gwn; bwe_n = bwen; lane_n = ln; oe_n = oen;
    sel = !csn && cshi && !cs2n;
    m = 4'h0;
    if (sel && !gwn) m = 4'hF;
    else if (sel && !bwen) m = ~ln;
    rd = sel && gwn && bwen;
    e.cyc = cyc + 2; e.rd = rd; e.data = ref_mem[a]; e.tag = tag;
    sb.push_back(e);
    if (m != 4'h0) ref_mem[a] = merge(ref_mem[a], d, m);
  endtask

  task automatic wr_gw(input int a, input logic [35:0] d, input logic bwen, input logic [3:0] ln, input string tag);
    op(a, d, 1'b0, 1'b1, 1'b0, 1'b0, bwen, ln, 1'b0, tag);
  endtask
  task automatic wr_lanes(input int a, input logic [35:0] d, input logic [3:0] ln, input string tag);
    op(a, d, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, ln, 1'b0, tag);
  endtask
  task automatic rd(input int a, input logic oen, input string tag);
    op(a, 36'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, oen, tag);
  endtask

  // Monitor: compares each queued expectation in its own cycle, away from the clock edge.
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0 && sb[0].cyc == cyc) begin
      exp_t e;
      logic exp_drv;
      e = sb.pop_front();
      exp_drv = e.rd && !oe_n;
      check(drive === exp_drv, {e.tag, " drive"}, 36'(drive), 36'(exp_drv));
      check(dout === (exp_drv ? e.data : 36'h0), {e.tag, " data"}, dout, exp_drv ? e.data : 36'h0);
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(drive === 1'b0, "R9 reset drive", 36'(drive), 36'h0);
    check(dout === 36'h0, "R9 reset data", dout, 36'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(drive === 1'b0 && dout === 36'h0, "R9 after reset", dout, 36'h0);

    // R2: global write fills every word, lane enables and byte strobe scrambled.
    for (int a = 0; a < DEPTH; a++)
      wr_gw(a, pattern(a, 0), 1'(a & 1), 4'(a * 5), "R2 global write");
    // R1 / R8: read every word back, parity bits included.
    for (int a = 0; a < DEPTH; a++)
      rd(a, 1'b0, "R1 R8 readback");

    // R3 / R4: partial lane writes with merge, each followed by a read.
    wr_lanes(5, 36'hF_FFFF_FFFF, 4'b1110, "R3 lane0");
    rd(5, 1'b0, "R3 R4 after lane0");
    wr_lanes(5, 36'h0_0000_0000, 4'b1001, "R3 lanes1,2");
    rd(5, 1'b0, "R3 R4 after lanes1,2");
    wr_lanes(5, 36'hA_5A5A_5A5A, 4'b0100, "R3 lanes0,1,3");
    rd(5, 1'b0, "R3 R4 after lanes0,1,3");
    wr_lanes(5, 36'h1_2345_6789, 4'b1111, "R3 no lane");
    rd(5, 1'b0, "R4 after empty write");

    // R5: no write strobe, lane enables low: a read, array unchanged.
    op(9, 36'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0, 1'b0, "R5 read with lanes low");
    rd(9, 1'b0, "R5 unchanged");

    // R6: each select in its inactive state blocks a global write and a read.
    op(12, 36'h3_3333_3333, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 1'b0, "R6 cs_n high write");
    op(12, 36'h4_4444_4444, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 1'b0, "R6 cs_hi low write");
    op(12, 36'h5_5555_5555, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 1'b0, "R6 cs2_n high write");
    op(12, 36'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 1'b0, "R6 deselected read");
    rd(12, 1'b0, "R6 word unchanged");

    // R7: output enable raised while a read result is pending.
    rd(20, 1'b0, "R7 read gated");
    rd(21, 1'b0, "R7 read ungated");
    op(0, 36'h0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 1'b1, "R7 idle oe high");
    op(0, 36'h0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, "R7 idle oe low");
    op(0, 36'h0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, "R7 idle");

    // R1: back-to-back write then read of one address, then byte write then read.
    wr_gw(30, 36'hC_0FFE_E123, 1'b1, 4'hF, "R1 write");
    rd(30, 1'b0, "R1 read after write");
    wr_lanes(30, 36'h8_8800_0000, 4'b0111, "R1 lane3 write");
    rd(30, 1'b0, "R1 R3 read after lane write");

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(sb.size() == 0, "R1 scoreboard drained", 36'(sb.size()), 36'h0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule